// File: doc/BRIEF.md
# Address-Range Shared Memory Lock

This block guards a shared memory used by several cores. Each core can claim a contiguous window of addresses by writing a low bound and a high bound into its own slot. Once both bounds are in, the slot becomes a pending claim. A central arbiter grants the claim when the window does not intersect any window already held. Cores that work on separate windows therefore reach the memory in parallel. A core whose window collides with a held window stalls until that window is released.

A core can instead ask for the whole memory as a global claim. The global claim and range claims exclude each other. A global claim waits until no range is held, and no range is granted while a global claim is held. Each core's access request is answered with a grant when the core holds a claim, and with a stall otherwise.

Each slot is a small state machine with five states:
- SL_IDLE: bounds are being loaded.
- SL_WAIT_RNG: a range claim is pending.
- SL_HOLD_RNG: a range is held.
- SL_WAIT_GLB: a global claim is pending.
- SL_HOLD_GLB: the global lock is held.

The transitions are:
- complete-bounds, from idle to range-wait.
- global-request, from idle to global-wait.
- win, from either wait state to its hold state.
- release, from any wait or hold state back to idle.

Top module: `range_lock_ctrl`

## Requirements
- R1: During and right after reset, no slot holds a range or the global lock, no error flag is set, and `acc_gnt` and `acc_stall` are all zero while `acc_req` is zero.
- R2: A slot's claim becomes pending at the clock edge where its second bound is written. The two bounds may be written in either order, in one cycle or in separate cycles. If nothing conflicts, `rng_held` rises one clock edge later.
- R3: Windows are inclusive. Two windows [a,b] and [c,d] collide when a<=d and c<=b, so a shared end address counts as a collision. A pending claim that collides with a held window is not granted.
- R4: Claims on non-colliding windows, including adjacent ones, are held at the same time, and their cores are granted access in the same cycle.
- R5: `lock_rel` at the clock edge returns a holding slot to idle. A claim blocked only by that holder is granted one clock edge after the release edge.
- R6: If the bounds complete with low > high, `bnd_err` of that slot rises at that edge and no claim is made. The flag clears on that slot's next bound write. A window with low == high is valid.
- R7: When colliding claims are pending in the same cycle, the lowest-numbered core is granted and the others keep waiting.
- R8: A range claim is not granted while any core holds the global lock.
- R9: A global claim (`glb_req`, taken only in idle) is not granted while any range is held or granted in the same cycle. At most one core holds the global lock, and among competing claims the lowest-numbered core wins.
- R10: Bound writes are ignored unless the slot is idle, so a held window cannot be moved. `lock_rel` on a pending claim cancels it.
- R11: `acc_gnt[i]` is `acc_req[i]` while core i holds a range or the global lock. `acc_stall[i]` is `acc_req[i]` while it holds neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bnd_lo_wr | input | NCORE | Per-core strobe: load low bound from that core's field of `bnd_data` |
| bnd_hi_wr | input | NCORE | Per-core strobe: load high bound from that core's field of `bnd_data` |
| bnd_data | input | NCORE*AW | Bound values; core i uses bits [i*AW +: AW] |
| glb_req | input | NCORE | Per-core request for the global lock |
| lock_rel | input | NCORE | Per-core release or cancel of the current claim |
| acc_req | input | NCORE | Per-core memory access request |
| acc_gnt | output | NCORE | Access may proceed |
| acc_stall | output | NCORE | Access must wait |
| rng_held | output | NCORE | Slot holds its address window |
| glb_held | output | NCORE | Slot holds the global lock |
| bnd_err | output | NCORE | Last completed bound pair was inverted |

## Verification
Two functions can fall in the same cycle: a release, and the arbitration of claims that the release unblocks. The same holds for a range claim and a global claim that become free together. The bench provokes both cases. It releases a holder while a colliding range waiter and a global waiter are pending. It also completes two colliding claims in the same cycle. It judges each case by which slot's held flag rises on the following edge and which slot stays in wait.

// File: rtl/range_lock_pkg.sv
package range_lock_pkg;

    typedef enum logic [2:0] {
        SL_IDLE     = 3'd0,
        SL_WAIT_RNG = 3'd1,
        SL_HOLD_RNG = 3'd2,
        SL_WAIT_GLB = 3'd3,
        SL_HOLD_GLB = 3'd4
    } slot_state_e;

endpackage

// File: rtl/rl_slot.sv
module rl_slot
    import range_lock_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lo_wr,
    input  logic          hi_wr,
    input  logic [AW-1:0] bnd_in,
    input  logic          glb_req,
    input  logic          rel,
    input  logic          win,
    output logic [AW-1:0] lo_o,
    output logic [AW-1:0] hi_o,
    output logic          err_o,
    output logic          wait_rng,
    output logic          hold_rng,
    output logic          wait_glb,
    output logic          hold_glb
);

    slot_state_e   state_q, state_d;
    logic [AW-1:0] lo_q, hi_q, lo_nx, hi_nx;
    logic          lo_ok_q, hi_ok_q, lo_ok_nx, hi_ok_nx;
    logic          err_q;
    logic          both_in, inverted, loading;

    // Candidate bound values if this cycle's writes were taken
    always_comb begin
        lo_nx    = lo_wr ? bnd_in : lo_q;
        hi_nx    = hi_wr ? bnd_in : hi_q;
        lo_ok_nx = lo_ok_q | lo_wr;
        hi_ok_nx = hi_ok_q | hi_wr;
        both_in  = lo_ok_nx & hi_ok_nx;
        inverted = lo_nx > hi_nx;
        loading  = (state_q == SL_IDLE) && !glb_req;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SL_IDLE: begin
                if (glb_req)
                    state_d = SL_WAIT_GLB;
                else if (both_in && !inverted)
                    state_d = SL_WAIT_RNG;
            end
            SL_WAIT_RNG: begin
                if (rel)
                    state_d = SL_IDLE;
                else if (win)
                    state_d = SL_HOLD_RNG;
            end
            SL_HOLD_RNG: begin
                if (rel)
                    state_d = SL_IDLE;
            end
            SL_WAIT_GLB: begin
                if (rel)
                    state_d = SL_IDLE;
                else if (win)
                    state_d = SL_HOLD_GLB;
            end
            SL_HOLD_GLB: begin
                if (rel)
                    state_d = SL_IDLE;
            end
            default: state_d = SL_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SL_IDLE;
        else
            state_q <= state_d;
    end

    // Bound registers, load flags and error flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q    <= '0;
            hi_q    <= '0;
            lo_ok_q <= 1'b0;
            hi_ok_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (loading) begin
            if (lo_wr) lo_q <= bnd_in;
            if (hi_wr) hi_q <= bnd_in;
            if (lo_wr || hi_wr)
                err_q <= both_in && inverted;
            if (both_in) begin
                lo_ok_q <= 1'b0;
                hi_ok_q <= 1'b0;
            end else begin
                lo_ok_q <= lo_ok_nx;
                hi_ok_q <= hi_ok_nx;
            end
        end else if (state_q == SL_IDLE) begin
            // global request taken: drop any partial load
            lo_ok_q <= 1'b0;
            hi_ok_q <= 1'b0;
        end
    end

    // Outputs decoded from state
    always_comb begin
        wait_rng = 1'b0;
        hold_rng = 1'b0;
        wait_glb = 1'b0;
        hold_glb = 1'b0;
        unique case (state_q)
            SL_IDLE:     ;
            SL_WAIT_RNG: wait_rng = 1'b1;
            SL_HOLD_RNG: hold_rng = 1'b1;
            SL_WAIT_GLB: wait_glb = 1'b1;
            SL_HOLD_GLB: hold_glb = 1'b1;
            default:     ;
        endcase
        lo_o  = lo_q;
        hi_o  = hi_q;
        err_o = err_q;
    end

endmodule

// File: rtl/rl_arbiter.sv
module rl_arbiter #(
    parameter int N  = 4,
    parameter int AW = 16
) (
    input  logic [N-1:0]    wait_r,
    input  logic [N-1:0]    hold_r,
    input  logic [N-1:0]    wait_g,
    input  logic [N-1:0]    hold_g,
    input  logic [N*AW-1:0] lo_flat,
    input  logic [N*AW-1:0] hi_flat,
    output logic [N-1:0]    win
);

    // Pairwise inclusive collision matrix
    logic [N-1:0] clash [N];

    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            if (i == j) begin : g_self
                assign clash[i][j] = 1'b0;
            end else begin : g_pair
                assign clash[i][j] =
                    (lo_flat[i*AW +: AW] <= hi_flat[j*AW +: AW]) &&
                    (lo_flat[j*AW +: AW] <= hi_flat[i*AW +: AW]);
            end
        end
    end

    // Index-ordered sweep: lower cores claim first in the same cycle
    always_comb begin
        logic [N-1:0] taken;
        logic         glb_busy;
        logic         rng_busy;
        taken    = hold_r;
        glb_busy = |hold_g;
        rng_busy = |hold_r;
        win      = '0;
        for (int i = 0; i < N; i++) begin
            if (wait_r[i] && !glb_busy && ((clash[i] & taken) == '0)) begin
                win[i]   = 1'b1;
                taken[i] = 1'b1;
                rng_busy = 1'b1;
            end else if (wait_g[i] && !glb_busy && !rng_busy) begin
                win[i]   = 1'b1;
                glb_busy = 1'b1;
            end
        end
    end

endmodule

// File: rtl/range_lock_ctrl.sv
module range_lock_ctrl #(
    parameter int NCORE = 4,
    parameter int AW    = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCORE-1:0]    bnd_lo_wr,
    input  logic [NCORE-1:0]    bnd_hi_wr,
    input  logic [NCORE*AW-1:0] bnd_data,
    input  logic [NCORE-1:0]    glb_req,
    input  logic [NCORE-1:0]    lock_rel,
    input  logic [NCORE-1:0]    acc_req,
    output logic [NCORE-1:0]    acc_gnt,
    output logic [NCORE-1:0]    acc_stall,
    output logic [NCORE-1:0]    rng_held,
    output logic [NCORE-1:0]    glb_held,
    output logic [NCORE-1:0]    bnd_err
);

    localparam int FLATW = NCORE * AW;

    logic [NCORE-1:0] wait_r, hold_r, wait_g, hold_g, win;
    logic [FLATW-1:0] lo_flat, hi_flat;

    for (genvar c = 0; c < NCORE; c++) begin : g_slot
        rl_slot #(.AW(AW)) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .lo_wr    (bnd_lo_wr[c]),
            .hi_wr    (bnd_hi_wr[c]),
            .bnd_in   (bnd_data[c*AW +: AW]),
            .glb_req  (glb_req[c]),
            .rel      (lock_rel[c]),
            .win      (win[c]),
            .lo_o     (lo_flat[c*AW +: AW]),
            .hi_o     (hi_flat[c*AW +: AW]),
            .err_o    (bnd_err[c]),
            .wait_rng (wait_r[c]),
            .hold_rng (hold_r[c]),
            .wait_glb (wait_g[c]),
            .hold_glb (hold_g[c])
        );
    end

    rl_arbiter #(.N(NCORE), .AW(AW)) u_arb (
        .wait_r  (wait_r),
        .hold_r  (hold_r),
        .wait_g  (wait_g),
        .hold_g  (hold_g),
        .lo_flat (lo_flat),
        .hi_flat (hi_flat),
        .win     (win)
    );

    always_comb begin
        rng_held  = hold_r;
        glb_held  = hold_g;
        acc_gnt   = acc_req & (hold_r | hold_g);
        acc_stall = acc_req & ~(hold_r | hold_g);
    end

endmodule

// File: rtl/rl_checker.sv
module rl_checker #(
    parameter int N  = 4,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [N-1:0]  lock_rel,
    input logic [N-1:0]  rng_held,
    input logic [N-1:0]  glb_held,
    input logic [N-1:0]  bnd_err,
    input logic [N*AW-1:0] lo_flat,
    input logic [N*AW-1:0] hi_flat
);

    assert_glb_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(glb_held));

    assert_mode_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !((|glb_held) && (|rng_held)));

    for (genvar i = 0; i < N; i++) begin : g_one
        assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (rng_held[i] && lock_rel[i]) |=> !rng_held[i]);

        assert_err_nolock_R6: assert property (@(posedge clk) disable iff (!rst_n)
            bnd_err[i] |-> !rng_held[i]);

        assert_held_fixed_R10: assert property (@(posedge clk) disable iff (!rst_n)
            rng_held[i] |=> (!rng_held[i] ||
                ($stable(lo_flat[i*AW +: AW]) && $stable(hi_flat[i*AW +: AW]))));

        for (genvar j = i + 1; j < N; j++) begin : g_two
            assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (rng_held[i] && rng_held[j]) |->
                !((lo_flat[i*AW +: AW] <= hi_flat[j*AW +: AW]) &&
                  (lo_flat[j*AW +: AW] <= hi_flat[i*AW +: AW])));
        end
    end

endmodule

bind range_lock_ctrl rl_checker #(.N(NCORE), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_rel (lock_rel),
    .rng_held (rng_held),
    .glb_held (glb_held),
    .bnd_err  (bnd_err),
    .lo_flat  (lo_flat),
    .hi_flat  (hi_flat)
);

// File: tb/sim_range_lock_ctrl.sv
module sim_range_lock_ctrl;

    localparam int N  = 4;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  bnd_lo_wr = '0, bnd_hi_wr = '0, glb_req = '0, lock_rel = '0, acc_req = '0;
    logic [N*AW-1:0] bnd_data = '0;
    logic [N-1:0]  acc_gnt, acc_stall, rng_held, glb_held, bnd_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [N-1:0] hr;
        logic [N-1:0] hg;
        logic [N-1:0] er;
        string        tag;
    } exp_t;

    exp_t sbq[$];

    always #5 clk = ~clk;

    range_lock_ctrl #(.NCORE(N), .AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .bnd_lo_wr(bnd_lo_wr), .bnd_hi_wr(bnd_hi_wr),
        .bnd_data(bnd_data), .glb_req(glb_req), .lock_rel(lock_rel), .acc_req(acc_req),
        .acc_gnt(acc_gnt), .acc_stall(acc_stall), .rng_held(rng_held),
        .glb_held(glb_held), .bnd_err(bnd_err)
    );

    // Monitor: compare queued expectations away from the active edge
    always @(negedge clk) begin : mon
        exp_t e;
        logic [N-1:0] eg, es;
        while (sbq.size() > 0) begin
            e  = sbq.pop_front();
            eg = acc_req & (e.hr | e.hg);
            es = acc_req & ~(e.hr | e.hg);
            checks++;
            if (rng_held !== e.hr || glb_held !== e.hg || bnd_err !== e.er ||
                acc_gnt !== eg || acc_stall !== es) begin
                fails++;
                $display("FAIL %s: held=%b glb=%b err=%b gnt=%b stall=%b expected held=%b glb=%b err=%b gnt=%b stall=%b",
                         e.tag, rng_held, glb_held, bnd_err, acc_gnt, acc_stall,
                         e.hr, e.hg, e.er, eg, es);
            end
        end
    end

    task automatic expect_st(input logic [N-1:0] hr, input logic [N-1:0] hg,
                             input logic [N-1:0] er, input string tag);
        exp_t e;
        e.hr = hr; e.hg = hg; e.er = er; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
        bnd_lo_wr = '0;
        bnd_hi_wr = '0;
        glb_req   = '0;
        lock_rel  = '0;
    endtask

    task automatic set_lo(input int c, input int v);
        bnd_lo_wr[c] = 1'b1;
        bnd_data[c*AW +: AW] = AW'(v);
    endtask

    task automatic set_hi(input int c, input int v);
        bnd_hi_wr[c] = 1'b1;
        bnd_data[c*AW +: AW] = AW'(v);
    endtask

    // Both bounds in one cycle needs two data values: low first, then high
    task automatic load(input int c, input int lo, input int hi);
        set_lo(c, lo);
        tick();
        set_hi(c, hi);
    endtask

    initial begin : watchdog
        #2000000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : drive
        repeat (3) @(posedge clk);
        #2;
        expect_st('0, '0, '0, "R1 in reset");
        tick();
        rst_n = 1'b1;
        tick();
        expect_st('0, '0, '0, "R1 after reset");
        tick();
        acc_req = '1;

        // R2: low then high in separate cycles, then granted
        load(0, 10, 20);
        tick();
        expect_st(4'b0000, '0, '0, "R2 pending after second bound");
        tick();
        expect_st(4'b0001, '0, '0, "R2 held one edge later, R11 gnt");

        // R2 high first, R4 disjoint concurrency
        set_hi(1, 40);
        tick();
        set_lo(1, 30);
        tick();
        expect_st(4'b0001, '0, '0, "R2 reverse order pending");
        tick();
        expect_st(4'b0011, '0, '0, "R4 disjoint both held");

        // R3: inclusive endpoint collision with core0 [10,20]
        load(2, 20, 25);
        tick();
        tick();
        expect_st(4'b0011, '0, '0, "R3 shared endpoint blocks, R11 stall");
        tick();
        expect_st(4'b0011, '0, '0, "R3 still blocked");

        // R5: release core0, core2 granted one edge later
        lock_rel[0] = 1'b1;
        tick();
        expect_st(4'b0010, '0, '0, "R5 released");
        tick();
        expect_st(4'b0110, '0, '0, "R5 blocked core granted");

        // R10: bound writes while holding are ignored
        load(2, 100, 110);
        tick();
        load(3, 22, 22);
        tick();
        tick();
        expect_st(4'b0110, '0, '0, "R10 held window unchanged, R6 lo==hi waits");
        lock_rel = 4'b0110;
        tick();
        expect_st(4'b0000, '0, '0, "R5 two released");
        tick();
        expect_st(4'b1000, '0, '0, "R6 single-address window held");
        lock_rel[3] = 1'b1;
        tick();
        expect_st('0, '0, '0, "R5 idle");

        // R6: inverted pair
        load(0, 50, 40);
        tick();
        expect_st('0, '0, 4'b0001, "R6 error raised");
        tick();
        expect_st('0, '0, 4'b0001, "R6 error stays, no lock");
        set_lo(0, 40);
        tick();
        expect_st('0, '0, 4'b0000, "R6 error cleared by write");
        set_hi(0, 50);
        tick();
        tick();
        expect_st(4'b0001, '0, '0, "R6 corrected pair held");
        lock_rel[0] = 1'b1;
        tick();

        // R7: colliding claims completing in the same cycle
        set_lo(1, 5);
        set_lo(3, 10);
        bnd_data[1*AW +: AW] = AW'(5);
        bnd_data[3*AW +: AW] = AW'(10);
        tick();
        bnd_hi_wr = 4'b1010;
        bnd_data[1*AW +: AW] = AW'(15);
        bnd_data[3*AW +: AW] = AW'(12);
        tick();
        tick();
        expect_st(4'b0010, '0, '0, "R7 lower core wins");
        lock_rel[1] = 1'b1;
        tick();
        tick();
        expect_st(4'b1000, '0, '0, "R7 loser granted after release");
        lock_rel[3] = 1'b1;
        tick();

        // R4: adjacent windows in the same cycle
        bnd_lo_wr = 4'b0101;
        bnd_data[0*AW +: AW] = AW'(0);
        bnd_data[2*AW +: AW] = AW'(4);
        tick();
        bnd_hi_wr = 4'b0101;
        bnd_data[0*AW +: AW] = AW'(3);
        bnd_data[2*AW +: AW] = AW'(7);
        tick();
        tick();
        expect_st(4'b0101, '0, '0, "R4 adjacent windows both held");
        lock_rel = 4'b0101;
        tick();

        // R9: global waits on a held range
        load(2, 60, 70);
        tick();
        tick();
        glb_req[0] = 1'b1;
        tick();
        tick();
        expect_st(4'b0100, 4'b0000, '0, "R9 global blocked by range");
        lock_rel[2] = 1'b1;
        tick();
        tick();
        expect_st(4'b0000, 4'b0001, '0, "R9 global granted after release");

        // R8: range waits on global; R9 second global waits
        load(1, 200, 210);
        tick();
        glb_req[3] = 1'b1;
        tick();
        tick();
        expect_st(4'b0000, 4'b0001, '0, "R8 range blocked by global");
        lock_rel[0] = 1'b1;
        tick();
        tick();
        expect_st(4'b0010, 4'b0000, '0, "R9 lower range beats higher global");
        lock_rel[1] = 1'b1;
        tick();
        tick();
        expect_st(4'b0000, 4'b1000, '0, "R9 global granted last");
        lock_rel[3] = 1'b1;
        tick();

        // R10: release cancels a pending claim
        load(1, 0, 9);
        tick();
        tick();
        load(0, 5, 6);
        tick();
        lock_rel[0] = 1'b1;
        tick();
        lock_rel[1] = 1'b1;
        tick();
        tick();
        expect_st('0, '0, '0, "R10 cancelled claim not granted");

        // R11: no request means no grant and no stall
        acc_req = '0;
        tick();
        expect_st('0, '0, '0, "R11 idle request lines");
        tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule